// File: doc/BRIEF.md
# Sequential Integer Divider, Long or Short Dividend

This block divides a dividend of twice the word width, or of one word width, by a one-word divisor. It returns a one-word quotient and a one-word remainder. With the default word width of 16 bits, that means 32/16 and 16/16 division. Both signed and unsigned operands are supported. Each operation is selected per request by two control pins: one picks signed or unsigned arithmetic, the other picks a long or a short dividend.

The dividend arrives as a high word and a low word. In short mode only the low word is used. It is sign-extended or zero-extended, depending on the arithmetic, before the iterations begin. Signed operands are first reduced to magnitudes. The magnitudes go through one restoring subtract-and-shift step per clock, one step per divisor bit. The signs are applied again at the output. Because of this, long and short divides take exactly the same number of cycles.

The interface is a plain request/completion handshake, not a stream. A start pulse is taken only while the block is idle, and it captures all operands on that edge. The block takes no back-pressure: the results stay on the outputs until the next accepted start. A caller that is not ready simply reads them later. A start pulse that arrives while busy is dropped.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy and done are 0. A start sampled high while busy is 0 is accepted, and busy reads 1 on the following cycle.
- R2: Unsigned long divide: for a dividend {hi,lo} and a nonzero divisor whose quotient fits one word, quotient = floor(dividend/divisor), remainder = dividend mod divisor, and error = 0.
- R3: Signed long divide (two's complement {hi,lo}, two's complement divisor): the quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R4: Unsigned short divide: the low word is zero-extended, and the value of the high word has no effect on quotient, remainder or error.
- R5: Signed short divide: bit DW-1 of the low word is copied into the upper half, and the high word has no effect.
- R6: A zero divisor sets error at completion in every mode.
- R7: A quotient outside the range of one word sets error: above 2^DW-1 unsigned, or outside -2^(DW-1)..2^(DW-1)-1 signed. Quotient and remainder are then unspecified.
- R8: A start that arrives while busy is 1 has no effect on the running operation, its result or its timing.
- R9: Done is high for exactly one cycle, DW cycles after the accepting edge, in the same cycle that busy returns to 0. This holds for both dividend widths.
- R10: While idle, quotient, remainder and error hold their last values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; honoured only while idle |
| signed_op | input | 1 | 1 = two's complement operands |
| long_op | input | 1 | 1 = dividend {dividend_hi,dividend_lo}, 0 = dividend_lo only |
| dividend_hi | input | DW | Upper word of the dividend |
| dividend_lo | input | DW | Lower word of the dividend |
| divisor | input | DW | Divisor |
| quotient | output | DW | Quotient, valid from done until the next accepted start |
| remainder | output | DW | Remainder, valid with quotient |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Zero divisor or quotient out of range, valid with quotient |

## Verification
A wrong partial remainder or a misaligned quotient shift register shows at the ports only when done rises, DW cycles after the start. It does not appear as a late signal; it appears as a wrong quotient or remainder for particular operand values. For that reason the bench compares every operand combination of a 4-bit configuration against integer division computed in the bench. A miscounting step counter shows in the same cycle as a shifted done pulse. A lost sign flag or a wrong overflow pre-check shows only for the operand values near the range limits, and the sweep covers all of those values.

// File: rtl/div_pkg.sv
package div_pkg;
  // per-operation arithmetic selection captured at the accepting edge
  typedef struct packed {
    logic is_signed;
    logic is_long;
  } div_mode_t;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_pkg::*;
#(
  parameter int DW = 16
) (
  input  div_mode_t          mode,
  input  logic [DW-1:0]      hi_word,
  input  logic [DW-1:0]      lo_word,
  input  logic [DW-1:0]      dvsr,
  output logic [2*DW-1:0]    n_mag,
  output logic [DW-1:0]      d_mag,
  output logic               q_negative,
  output logic               r_negative,
  output logic               pre_err
);
  localparam int W2 = 2 * DW;

  logic [W2-1:0] ext;
  logic          n_neg;
  logic          d_neg;

  // widen the short dividend according to the arithmetic
  always_comb begin
    if (mode.is_long)
      ext = {hi_word, lo_word};
    else if (mode.is_signed)
      ext = {{DW{lo_word[DW-1]}}, lo_word};
    else
      ext = {{DW{1'b0}}, lo_word};
  end

  assign n_neg = mode.is_signed & ext[W2-1];
  assign d_neg = mode.is_signed & dvsr[DW-1];

  assign n_mag = n_neg ? ('0 - ext) : ext;
  assign d_mag = d_neg ? ('0 - dvsr) : dvsr;

  assign q_negative = n_neg ^ d_neg;
  assign r_negative = n_neg;

  // a high half not below the divisor means a quotient of more than DW bits
  assign pre_err = (d_mag == '0) || (n_mag[W2-1:DW] >= d_mag);
endmodule

// File: rtl/div_step_core.sv
module div_step_core #(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2*DW-1:0]   n_mag,
  input  logic [DW-1:0]     d_mag,
  output logic              take_o,
  output logic [DW-1:0]     q_o,
  output logic [DW-1:0]     r_o,
  output logic [DW-1:0]     d_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          fits;

  assign take_o = start && !busy_o;

  // one restoring step: shift in next dividend bit, subtract if it fits
  assign trial = {r_o, q_o[DW-1]};
  assign diff  = trial - {1'b0, d_o};
  assign fits  = trial >= {1'b0, d_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o    <= '0;
      r_o    <= '0;
      d_o    <= '0;
      cnt    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take_o) begin
        r_o    <= n_mag[2*DW-1:DW];
        q_o    <= n_mag[DW-1:0];
        d_o    <= d_mag;
        cnt    <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        r_o <= fits ? diff[DW-1:0] : trial[DW-1:0];
        q_o <= {q_o[DW-2:0], fits};
        cnt <= cnt + CW'(1);
        if (cnt == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R8: a request during an operation neither restarts nor stalls the count
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start && (cnt != LAST) |=> busy_o && (cnt == $past(cnt) + CW'(1)));

  // R9: the operation ends exactly when done is raised
  p_end_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int DW = 16
) (
  input  logic          is_signed,
  input  logic          q_negative,
  input  logic          r_negative,
  input  logic          pre_err,
  input  logic [DW-1:0] q_mag,
  input  logic [DW-1:0] r_mag,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder,
  output logic          error
);
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

  logic range_err;

  assign quotient  = q_negative ? ('0 - q_mag) : q_mag;
  assign remainder = r_negative ? ('0 - r_mag) : r_mag;

  // signed results: negative side reaches one step further than positive
  always_comb begin
    if (!is_signed)
      range_err = 1'b0;
    else if (q_negative)
      range_err = q_mag > HALF;
    else
      range_err = q_mag[DW-1];
  end

  assign error = pre_err || range_err;
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          signed_op,
  input  logic          long_op,
  input  logic [DW-1:0] dividend_hi,
  input  logic [DW-1:0] dividend_lo,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder,
  output logic          busy,
  output logic          done,
  output logic          error
);
  div_mode_t         mode_in;
  logic [2*DW-1:0]   n_mag;
  logic [DW-1:0]     d_mag;
  logic              q_neg_in, r_neg_in, pre_err_in;
  logic              take;
  logic [DW-1:0]     q_mag, r_mag, d_held;

  logic              signed_q, q_neg_q, r_neg_q, pre_err_q;

  assign mode_in = '{is_signed: signed_op, is_long: long_op};

  div_operand_prep #(.DW(DW)) u_prep (
    .mode       (mode_in),
    .hi_word    (dividend_hi),
    .lo_word    (dividend_lo),
    .dvsr       (divisor),
    .n_mag      (n_mag),
    .d_mag      (d_mag),
    .q_negative (q_neg_in),
    .r_negative (r_neg_in),
    .pre_err    (pre_err_in)
  );

  div_step_core #(.DW(DW)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .n_mag  (n_mag),
    .d_mag  (d_mag),
    .take_o (take),
    .q_o    (q_mag),
    .r_o    (r_mag),
    .d_o    (d_held),
    .busy_o (busy),
    .done_o (done)
  );

  // sign and error context kept for the whole operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      signed_q  <= 1'b0;
      q_neg_q   <= 1'b0;
      r_neg_q   <= 1'b0;
      pre_err_q <= 1'b0;
    end else if (take) begin
      signed_q  <= signed_op;
      q_neg_q   <= q_neg_in;
      r_neg_q   <= r_neg_in;
      pre_err_q <= pre_err_in;
    end
  end

  div_result_fix #(.DW(DW)) u_fix (
    .is_signed  (signed_q),
    .q_negative (q_neg_q),
    .r_negative (r_neg_q),
    .pre_err    (pre_err_q),
    .q_mag      (q_mag),
    .r_mag      (r_mag),
    .quotient   (quotient),
    .remainder  (remainder),
    .error      (error)
  );

  // R1: an idle request is taken on the next edge
  p_start_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: results hold while idle
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) |-> $stable(quotient) && $stable(remainder) && $stable(error));

  // R2: a valid result leaves a remainder magnitude below the divisor
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !pre_err_q |-> r_mag < d_held);
endmodule

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  localparam int BW = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          signed_op = 1'b0;
  logic          long_op = 1'b0;
  logic [BW-1:0] dividend_hi = '0;
  logic [BW-1:0] dividend_lo = '0;
  logic [BW-1:0] divisor = '0;
  logic [BW-1:0] quotient, remainder;
  logic          busy, done, error;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_divider #(.DW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_op(signed_op),
    .long_op(long_op), .dividend_hi(dividend_hi), .dividend_lo(dividend_lo),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit sgn, input bit lng, input logic [BW-1:0] hi,
                        input logic [BW-1:0] lo, input logic [BW-1:0] dv,
                        input bit poke, input bit hold);
    int n, d, q, r, lat;
    bit e;
    string tag;
    logic [BW-1:0] eq, er, sq, sr;
    logic se;
    // expected values from integer arithmetic
    if (lng) begin
      n = int'({hi, lo});
      if (sgn && n >= 2**(2*BW-1)) n -= 2**(2*BW);
    end else begin
      n = int'(lo);
      if (sgn && n >= 2**(BW-1)) n -= 2**BW;
    end
    d = int'(dv);
    if (sgn && d >= 2**(BW-1)) d -= 2**BW;
    q = 0; r = 0;
    if (d == 0) e = 1'b1;
    else begin
      q = n / d;
      r = n % d;
      e = sgn ? (q < -(2**(BW-1)) || q > 2**(BW-1)-1) : (q > 2**BW-1);
    end
    eq = BW'(q);
    er = BW'(r);
    if (d == 0) tag = "R6";
    else if (e) tag = "R7";
    else if (lng) tag = sgn ? "R3" : "R2";
    else tag = sgn ? "R5" : "R4";

    @(negedge clk);
    signed_op = sgn; long_op = lng;
    dividend_hi = hi; dividend_lo = lo; divisor = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    if (poke) begin
      // R8: a second request mid-operation with other operands
      signed_op = ~sgn; long_op = ~lng;
      dividend_hi = ~hi; dividend_lo = ~lo; divisor = dv + BW'(1);
      start = 1'b1;
    end
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 3*BW);
    chk(lat == BW, poke ? "R8" : "R9", "latency", lat, BW);
    chk(error == e, tag, "error", int'(error), int'(e));
    if (!e) begin
      chk(quotient == eq && remainder == er, poke ? "R8" : tag, "quot*256+rem",
          int'(quotient)*256 + int'(remainder), int'(eq)*256 + int'(er));
    end
    if (hold) begin
      sq = quotient; sr = remainder; se = error;
      dividend_hi = ~hi; dividend_lo = lo + BW'(1); divisor = ~dv;
      @(negedge clk);
      chk(done == 1'b0, "R9", "done pulse width", int'(done), 0);
      chk(quotient == sq && remainder == sr && error == se, "R10", "held result",
          int'(quotient)*256 + int'(remainder), int'(sq)*256 + int'(sr));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done",
        int'(busy)*2 + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset",
        int'(busy)*2 + int'(done), 0);

    // long dividend, every combination in both arithmetics
    for (int s = 0; s < 2; s++)
      for (int nv = 0; nv < 2**(2*BW); nv++)
        for (int dv = 0; dv < 2**BW; dv++)
          run_op(s[0], 1'b1, BW'(nv >> BW), BW'(nv), BW'(dv),
                 ((nv + dv) % 7) == 0, ((nv + dv) % 5) == 0);

    // short dividend: high word set to varying junk (R4, R5)
    for (int s = 0; s < 2; s++)
      for (int lo = 0; lo < 2**BW; lo++)
        for (int dv = 0; dv < 2**BW; dv++)
          run_op(s[0], 1'b0, BW'(lo*3 + dv + 5), BW'(lo), BW'(dv),
                 ((lo + dv) % 6) == 0, ((lo + dv) % 4) == 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule